// File: doc/BRIEF.md
# Regulator fault supervisor

This block is the digital sequencer that sits beside a switching regulator's power stage. It takes the enable level and a set of condition inputs from analog sensing. These are a die-temperature code, a peak-current-limit flag, an undervoltage-lockout flag, an output-in-regulation flag and a pulse that marks the end of the soft-start ramp. From these it decides whether the stage switches, whether the stage is parked in high impedance, whether the output is discharged, and whether power-good is reported.

There are four operating phases: off, ramp (soft-start), on (regulating) and tripped (fault). Every fault source leads into the single tripped phase. The tripped phase retries on its own after a wait. Over-temperature has hysteresis, so a hot die keeps the block from restarting until it has cooled. Current limit has to persist before it counts as a fault. Output discharge is used only when the regulator is off because enable is low, and never when it is off because of a fault. All time limits are counts of clock cycles and are set by parameters.

Top module: `reg_fault_supervisor`

## Requirements
- R1: While the synchronous active-low reset is low, and in the cycle after it is released, the block is in the off phase. In that phase dis_en=1 and sw_en=0, stage_hiz=0 and pgood=0.
- R2: A rising edge of en in the off phase enters the ramp phase at the next clock edge (sw_en=1). en low in any phase enters the off phase at the next clock edge (dis_en=1, pgood=0).
- R3: If ss_done is high in the ramp phase with vout_ok high, the block enters the on phase and pgood goes to 1 at the next edge. If vout_ok is low at that point, the block enters the tripped phase instead.
- R4: If ss_done has not arrived after SS_CYCLES cycles in the ramp phase, the block enters the tripped phase.
- R5: A current-limit fault is declared when ilim is high for OCP_CYCLES consecutive cycles during ramp or on. The block then enters tripped at the next edge. A single low cycle restarts the count.
- R6: A die_temp code strictly above TRIP_CODE in ramp or on enters tripped. A code equal to TRIP_CODE does not. After a trip, restart is held off until die_temp has been at or below CLEAR_CODE.
- R7: In the tripped phase sw_en=0, stage_hiz=1, dis_en=0 and pgood=0.
- R8: With no lockout and a cool die, the tripped phase lasts exactly RETRY_CYCLES cycles, and the block then re-enters ramp.
- R9: uvlo high in ramp or on enters tripped. While uvlo is high in tripped, the block stays tripped and the retry wait restarts. Ramp is re-entered RETRY_CYCLES cycles after uvlo clears.
- R10: Exactly one of sw_en, stage_hiz and dis_en is high at all times after reset. pgood is high only in the on phase, and it rises only at the edge that ends a successful ramp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Regulator enable level |
| die_temp | input | TEMP_W | Die temperature code |
| ilim | input | 1 | Peak current limit active |
| uvlo | input | 1 | Undervoltage lockout active |
| vout_ok | input | 1 | Output within regulation window |
| ss_done | input | 1 | Soft-start ramp finished (pulse) |
| sw_en | output | 1 | Power stage switching enable |
| stage_hiz | output | 1 | Power stage held high impedance |
| dis_en | output | 1 | Output discharge path enable |
| pgood | output | 1 | Power-good level |

## Verification
The bench sets OCP_CYCLES to 20, RETRY_CYCLES to 40 and SS_CYCLES to 30, and keeps the trip and clear codes at 150 and 130. These short limits let every retry, timeout and persistence window run to completion many times within a few hundred cycles. The bench can therefore hit the exact expiry cycle and the cycle just before it, reach the temperature codes on each side of both thresholds, and send a lockout that lasts longer than a whole retry wait.

// File: rtl/reg_fault_supervisor.sv
module reg_fault_supervisor #(
  parameter int TEMP_W       = 8,
  parameter int TRIP_CODE    = 150,
  parameter int CLEAR_CODE   = 130,
  parameter int OCP_CYCLES   = 700,
  parameter int RETRY_CYCLES = 3000000,
  parameter int SS_CYCLES    = 100000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [TEMP_W-1:0] die_temp,
  input  logic              ilim,
  input  logic              uvlo,
  input  logic              vout_ok,
  input  logic              ss_done,
  output logic              sw_en,
  output logic              stage_hiz,
  output logic              dis_en,
  output logic              pgood
);
  localparam int TMAX = (RETRY_CYCLES > SS_CYCLES) ? RETRY_CYCLES : SS_CYCLES;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int OW   = $clog2(OCP_CYCLES + 1);
  localparam logic [TEMP_W-1:0] TRIP_V  = TEMP_W'(TRIP_CODE);
  localparam logic [TEMP_W-1:0] CLEAR_V = TEMP_W'(CLEAR_CODE);
  localparam logic [TW-1:0] RETRY_END = TW'(RETRY_CYCLES - 1);
  localparam logic [TW-1:0] SS_END    = TW'(SS_CYCLES - 1);
  localparam logic [OW-1:0] OCP_END   = OW'(OCP_CYCLES - 1);

  typedef enum logic [1:0] {S_OFF, S_RAMP, S_ON, S_TRIP} st_t;

  st_t           st, nxt;
  logic [TW-1:0] tmr;
  logic [OW-1:0] ocp_cnt;
  logic          en_q, hot_q, pg_q;

  wire active   = (st == S_RAMP) || (st == S_ON);
  wire ot_trip  = die_temp > TRIP_V;
  wire cool     = die_temp <= CLEAR_V;
  wire ocp_hit  = ilim && (ocp_cnt == OCP_END);
  wire hard_flt = uvlo || ot_trip || ocp_hit;
  wire retry_ok = !uvlo && !ot_trip && !hot_q && (tmr == RETRY_END);

  always_comb begin
    nxt = st;
    unique case (st)
      S_OFF:  if (en && !en_q) nxt = S_RAMP;
      S_RAMP: begin
        if (!en)               nxt = S_OFF;
        else if (hard_flt)     nxt = S_TRIP;
        else if (ss_done)      nxt = vout_ok ? S_ON : S_TRIP;
        else if (tmr == SS_END) nxt = S_TRIP;
      end
      S_ON: begin
        if (!en)           nxt = S_OFF;
        else if (hard_flt) nxt = S_TRIP;
      end
      S_TRIP: begin
        if (!en)           nxt = S_OFF;
        else if (retry_ok) nxt = S_RAMP;
      end
      default: nxt = S_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_OFF;
      tmr     <= '0;
      ocp_cnt <= '0;
      en_q    <= 1'b0;
      hot_q   <= 1'b0;
      pg_q    <= 1'b0;
    end else begin
      st   <= nxt;
      en_q <= en;
      pg_q <= (nxt == S_ON);
      if (ot_trip)   hot_q <= 1'b1;
      else if (cool) hot_q <= 1'b0;
      ocp_cnt <= (active && ilim) ? ocp_cnt + 1'b1 : '0;
      if (nxt != st) tmr <= '0;
      else if (st == S_RAMP) tmr <= tmr + 1'b1;
      else if (st == S_TRIP) begin
        if (uvlo)                 tmr <= '0;
        else if (tmr != RETRY_END) tmr <= tmr + 1'b1;
      end else tmr <= '0;
    end
  end

  assign sw_en     = active;
  assign stage_hiz = (st == S_TRIP);
  assign dis_en    = (st == S_OFF);
  assign pgood     = pg_q;
endmodule

// File: rtl/reg_fault_supervisor_chk.sv
module reg_fault_supervisor_chk #(
  parameter int TEMP_W    = 8,
  parameter int TRIP_CODE = 150
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic [TEMP_W-1:0] die_temp,
  input logic              uvlo,
  input logic              vout_ok,
  input logic              ss_done,
  input logic              sw_en,
  input logic              stage_hiz,
  input logic              dis_en,
  input logic              pgood
);
  p_one_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({sw_en, stage_hiz, dis_en}) == 1);

  p_pg_needs_sw_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pgood |-> sw_en);

  p_pg_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pgood) |-> ($past(sw_en) && $past(ss_done) && $past(vout_ok) && $past(en)));

  p_en_low_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (dis_en && !pgood));

  p_uvlo_trip_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && uvlo && !dis_en) |=> stage_hiz);

  p_hot_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && stage_hiz && die_temp > TEMP_W'(TRIP_CODE)) |=> stage_hiz);

  p_trip_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stage_hiz |-> (!sw_en && !dis_en && !pgood));
endmodule

bind reg_fault_supervisor reg_fault_supervisor_chk #(
  .TEMP_W(TEMP_W), .TRIP_CODE(TRIP_CODE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .die_temp(die_temp), .uvlo(uvlo),
  .vout_ok(vout_ok), .ss_done(ss_done), .sw_en(sw_en), .stage_hiz(stage_hiz),
  .dis_en(dis_en), .pgood(pgood)
);

// File: tb/sim_reg_fault_supervisor.sv
`timescale 1ns/1ps
module sim_reg_fault_supervisor;
  localparam int TW = 8, TRIP = 150, CLR = 130, OCP = 20, RETRY = 40, SST = 30;
  localparam int M_OFF = 0, M_RAMP = 1, M_ON = 2, M_TRIP = 3;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, ilim = 1'b0, uvlo = 1'b0;
  logic vout_ok = 1'b0, ss_done = 1'b0;
  logic [TW-1:0] die_temp = 8'd25;
  logic sw_en, stage_hiz, dis_en, pgood;

  reg_fault_supervisor #(.TEMP_W(TW), .TRIP_CODE(TRIP), .CLEAR_CODE(CLR),
    .OCP_CYCLES(OCP), .RETRY_CYCLES(RETRY), .SS_CYCLES(SST)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .die_temp(die_temp), .ilim(ilim),
    .uvlo(uvlo), .vout_ok(vout_ok), .ss_done(ss_done), .sw_en(sw_en),
    .stage_hiz(stage_hiz), .dis_en(dis_en), .pgood(pgood));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;

  int mode = M_OFF, ss_age = 0, clear_run = 0, ilim_run = 0;
  bit hot = 0, en_prev = 0;

  function automatic logic [3:0] pattern(int m);
    case (m)
      M_OFF:  return 4'b0010;
      M_RAMP: return 4'b1000;
      M_ON:   return 4'b1001;
      default: return 4'b0100;
    endcase
  endfunction

  always @(posedge clk) begin
    int nm;
    bit ot, ocp;
    if (!rst_n) begin
      mode = M_OFF; ss_age = 0; clear_run = 0; ilim_run = 0; hot = 0; en_prev = 0;
    end else begin
      ot = die_temp > TRIP;
      ilim_run = ((mode == M_RAMP || mode == M_ON) && ilim) ? ilim_run + 1 : 0;
      ocp = ilim_run >= OCP;
      nm = mode;
      case (mode)
        M_OFF: if (en && !en_prev) nm = M_RAMP;
        M_RAMP: begin
          ss_age++;
          if (!en) nm = M_OFF;
          else if (uvlo || ot || ocp) nm = M_TRIP;
          else if (ss_done) nm = vout_ok ? M_ON : M_TRIP;
          else if (ss_age >= SST) nm = M_TRIP;
        end
        M_ON: begin
          if (!en) nm = M_OFF;
          else if (uvlo || ot || ocp) nm = M_TRIP;
        end
        default: begin
          clear_run = uvlo ? 0 : clear_run + 1;
          if (!en) nm = M_OFF;
          else if (!uvlo && clear_run >= RETRY && !ot && !hot) nm = M_RAMP;
        end
      endcase
      if (nm != mode) begin ss_age = 0; clear_run = 0; end
      mode = nm;
      if (ot) hot = 1;
      else if (die_temp <= CLR) hot = 0;
      en_prev = en;
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc >= 2) begin
      checks++;
      if ({sw_en, stage_hiz, dis_en, pgood} !== pattern(mode)) begin
        errors++;
        $display("FAIL R10 cycle %0d: outputs %b expected %b", cyc,
                 {sw_en, stage_hiz, dis_en, pgood}, pattern(mode));
      end
    end
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected end before cycle 150000");
      summary();
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_mode(string req, int m);
    checks++;
    if ({sw_en, stage_hiz, dis_en, pgood} !== pattern(m)) begin
      errors++;
      $display("FAIL %s: outputs %b expected %b", req,
               {sw_en, stage_hiz, dis_en, pgood}, pattern(m));
    end
  endtask

  task automatic pulse_done();
    ss_done = 1'b1;
    wait_cyc(1);
    ss_done = 1'b0;
  endtask

  initial begin
    wait_cyc(3);
    check_mode("R1 in reset", M_OFF);
    rst_n = 1'b1;
    wait_cyc(1);
    check_mode("R1 after release", M_OFF);

    en = 1'b1;
    wait_cyc(1);
    check_mode("R2 rise to ramp", M_RAMP);
    vout_ok = 1'b1;
    wait_cyc(4);
    pulse_done();
    check_mode("R3 good ramp to on", M_ON);

    ilim = 1'b1; wait_cyc(OCP - 1); ilim = 1'b0;
    wait_cyc(2);
    check_mode("R5 short limit ignored", M_ON);
    ilim = 1'b1; wait_cyc(OCP - 1);
    check_mode("R5 one cycle before fault", M_ON);
    wait_cyc(1);
    check_mode("R5 persistent limit", M_TRIP);
    check_mode("R7 tripped outputs", M_TRIP);
    ilim = 1'b0;
    wait_cyc(RETRY - 1);
    check_mode("R8 still waiting", M_TRIP);
    wait_cyc(1);
    check_mode("R8 retry ramp", M_RAMP);
    pulse_done();
    check_mode("R3 back on", M_ON);

    die_temp = 8'd150; wait_cyc(3);
    check_mode("R6 at trip code", M_ON);
    die_temp = 8'd151; wait_cyc(1);
    check_mode("R6 over temperature", M_TRIP);
    die_temp = 8'd140; wait_cyc(RETRY + 5);
    check_mode("R6 hysteresis hold", M_TRIP);
    die_temp = 8'd131; wait_cyc(3);
    check_mode("R6 above clear code", M_TRIP);
    die_temp = 8'd130; wait_cyc(3);
    check_mode("R6 cooled restart", M_RAMP);
    die_temp = 8'd60;

    wait_cyc(SST);
    check_mode("R4 ramp timeout", M_TRIP);
    wait_cyc(RETRY + 1);
    check_mode("R8 ramp after timeout", M_RAMP);
    vout_ok = 1'b0;
    pulse_done();
    check_mode("R3 done without regulation", M_TRIP);
    vout_ok = 1'b1;

    uvlo = 1'b1; wait_cyc(RETRY + 10);
    check_mode("R9 lockout holds", M_TRIP);
    uvlo = 1'b0; wait_cyc(RETRY - 1);
    check_mode("R9 wait restarts", M_TRIP);
    wait_cyc(2);
    check_mode("R9 retry after clear", M_RAMP);
    uvlo = 1'b1; wait_cyc(1);
    check_mode("R9 lockout in ramp", M_TRIP);
    uvlo = 1'b0;

    en = 1'b0; wait_cyc(1);
    check_mode("R2 disable from trip", M_OFF);
    wait_cyc(3);
    en = 1'b1; wait_cyc(1);
    check_mode("R2 re-enable", M_RAMP);
    pulse_done();
    check_mode("R10 on with pgood", M_ON);
    en = 1'b0; wait_cyc(1);
    check_mode("R2 disable from on", M_OFF);
    wait_cyc(3);
    summary();
  end
endmodule